// File: doc/BRIEF.md
# Cut-Through Packet Buffer Controller

This block sits in one direction of an Ethernet MAC datapath and holds a single packet at a time between a byte-wide producer and a byte-wide consumer. Bytes arrive on a valid/ready write port that carries start and end markers. They leave on a valid/ready read port that repeats the end marker. The block decides, packet by packet, when the read side may begin to drain the store.

There are two ways to start forwarding. In plain store-and-forward operation the read side opens only after the last byte of the packet has been stored. In low-latency operation it opens as soon as the packet's stored byte count reaches a programmable fill watermark. In transmit direction the watermark has a floor of 20 bytes. A frame flagged as spanning several buffers always falls back to store-and-forward. The enable bit and the watermark share one configuration word. The block samples that word, the direction input and the multi-buffer flag only on the byte that opens a packet.

Top module: `cutthru_pktbuf`

## Requirements
- R1: After reset, rd_valid is 0 and wr_ready is 1.
- R2: With the enable bit (cfg_word bit WM_W) clear, rd_valid first rises in the cycle after the byte carrying wr_eop is accepted, and not before.
- R3: With the enable bit set, rd_valid first rises in the cycle after the packet's N-th byte is accepted, where N is the effective watermark taken from cfg_word bits WM_W-1:0.
- R4: In transmit direction (cfg_tx = 1), a programmed watermark below 20 acts as 20, and a larger value is used unchanged.
- R5: In receive direction (cfg_tx = 0), the programmed watermark is used unchanged. The values 0 and 1 both start forwarding after the first byte.
- R6: A packet whose opening byte carries wr_multi = 1 is forwarded store-and-forward, whatever the enable bit says.
- R7: If wr_eop is accepted before the watermark is reached, rd_valid rises in the next cycle.
- R8: Changes to cfg_word or cfg_tx after a packet's opening byte do not affect that packet's start point.
- R9: wr_ready is 0 while the store holds DEPTH bytes. Every accepted byte leaves on the read side once, in order, with rd_eop set only on the packet's last byte.
- R10: Once forwarding has begun, rd_valid is 0 whenever the store is empty.
- R11: After wr_eop is accepted, wr_ready stays 0 until the byte marked rd_eop has been read. In the cycle after that read, wr_ready is 1 again.
- R12: A byte offered between packets without wr_sop is accepted and discarded. It never appears on the read side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | WM_W+1 | Bit WM_W: low-latency enable; bits WM_W-1:0: fill watermark |
| cfg_tx | input | 1 | Direction: 1 transmit (watermark floor applies), 0 receive |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte can be taken |
| wr_data | input | DATA_W | Write byte |
| wr_sop | input | 1 | Byte opens a packet |
| wr_eop | input | 1 | Byte closes a packet |
| wr_multi | input | 1 | Packet spans several buffers (sampled with the opening byte) |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | DATA_W | Read byte |
| rd_eop | output | 1 | Read byte is the packet's last |

## Verification
The bench builds the block with DEPTH = 32, WM_W = 8 and the default transmit floor of 20. With these values a clamped transmit window of 20 to 25 bytes fits in the store, so the start point can be observed without the read side draining anything. A 40-byte receive packet overruns the 32-entry store, which exercises back-pressure on the write side and the later resumption of writes. A writer that offers one byte every third cycle against an eager reader empties the store mid-packet many times, so the read stall is exercised repeatedly.

// File: rtl/cutthru_pkg.sv
// Shared types for the cut-through packet buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package cutthru_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // between packets
        ST_FILL = 2'd1,   // storing, read side closed
        ST_FWD  = 2'd2    // read side open
    } fwd_st_t;
endpackage

// File: rtl/pb_store.sv
// Byte store with an end marker per entry and an occupancy count.
// Assumes: the caller never pushes when full or pops when empty.
module pb_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_eop,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_eop,
    output logic              full,
    output logic              empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DATA_W:0] mem [DEPTH];
    logic [AW-1:0]   wptr, rptr;
    logic [CW-1:0]   count;

    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign pop_data = mem[rptr][DATA_W-1:0];
    assign pop_eop  = mem[rptr][DATA_W];

    // Store an entry on each push.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= {push_eop, push_data};
    end

    // Advance the pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // R9
    overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R10
    underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/pb_wm_resolve.sv
// Turns the configuration word into an effective enable and watermark.
// Assumes: TX_MIN fits in WM_W bits.
module pb_wm_resolve #(
    parameter int WM_W   = 8,
    parameter int TX_MIN = 20
) (
    input  logic [WM_W:0]   cfg_word,
    input  logic            cfg_tx,
    input  logic            multi,
    output logic            part_en,
    output logic [WM_W-1:0] wm_eff
);
    localparam logic [WM_W-1:0] FLOOR = WM_W'(TX_MIN);

    logic [WM_W-1:0] wm_raw;
    assign wm_raw = cfg_word[WM_W-1:0];

    // Cut-through applies only to single-buffer frames; the floor applies in transmit only.
    always_comb begin
        part_en = cfg_word[WM_W] && !multi;
        wm_eff  = (cfg_tx && (wm_raw < FLOOR)) ? FLOOR : wm_raw;
    end
endmodule

// File: rtl/pb_fwd_ctrl.sv
// Per-packet state machine: latches settings on the opening byte,
// counts stored bytes and opens the read side at the watermark or the end marker.
// Assumes: one packet in the store at a time.
module pb_fwd_ctrl #(
    parameter int WM_W   = 8,
    parameter int TX_MIN = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    input  logic            wr_sop,
    input  logic            wr_eop,
    input  logic            rd_ready,
    input  logic            full,
    input  logic            empty,
    input  logic            pop_eop,
    input  logic            part_en_in,
    input  logic [WM_W-1:0] wm_in,
    input  logic            tx_in,
    output logic            wr_ready,
    output logic            push,
    output logic            rd_valid,
    output logic            pop
);
    import cutthru_pkg::*;

    localparam int NW = WM_W + 1;
    localparam logic [NW-1:0] CNT_MAX = '1;

    fwd_st_t         state;
    logic            eop_in;
    logic            part_q, tx_q;
    logic [WM_W-1:0] wm_q;
    logic [NW-1:0]   pkt_cnt, cnt_inc;
    logic            open_now, fill_hit;

    // Handshake decode for both ports.
    always_comb begin
        wr_ready = !full && !eop_in;
        push     = wr_valid && wr_ready && ((state != ST_IDLE) || wr_sop);
        rd_valid = (state == ST_FWD) && !empty;
        pop      = rd_valid && rd_ready;
        cnt_inc  = (pkt_cnt == CNT_MAX) ? pkt_cnt : pkt_cnt + 1'b1;
        fill_hit = part_q && (cnt_inc >= {1'b0, wm_q});
        open_now = wr_eop || (part_en_in && (wm_in <= WM_W'(1)));
    end

    // Packet sequencing and settings capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            eop_in  <= 1'b0;
            part_q  <= 1'b0;
            tx_q    <= 1'b0;
            wm_q    <= '0;
            pkt_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (push) begin
                    part_q  <= part_en_in;
                    wm_q    <= wm_in;
                    tx_q    <= tx_in;
                    pkt_cnt <= NW'(1);
                    eop_in  <= wr_eop;
                    state   <= open_now ? ST_FWD : ST_FILL;
                end
                ST_FILL: if (push) begin
                    pkt_cnt <= cnt_inc;
                    eop_in  <= wr_eop;
                    if (wr_eop || fill_hit) state <= ST_FWD;
                end
                ST_FWD: begin
                    if (push && wr_eop) eop_in <= 1'b1;
                    if (pop && pop_eop) begin
                        eop_in <= 1'b0;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    sf_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FWD && $past(state) != ST_FWD && !part_q) |-> eop_in);
    // R3
    wm_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FWD && $past(state) != ST_FWD && !eop_in) |-> (pkt_cnt >= {1'b0, wm_q}));
    // R4
    tx_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && tx_q) |-> (wm_q >= WM_W'(TX_MIN)));
    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> ($stable(wm_q) && $stable(part_q)));
endmodule

// File: rtl/cutthru_pktbuf.sv
// Top: single-packet buffer with store-and-forward or watermark cut-through start.
// Assumes: in store-and-forward use a packet fits in DEPTH bytes, and in
// cut-through use the watermark does not exceed DEPTH.
module cutthru_pktbuf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int WM_W   = 8,
    parameter int TX_MIN = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WM_W:0]     cfg_word,
    input  logic              cfg_tx,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic              wr_multi,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_eop
);
    logic            push, pop, full, empty, pop_eop;
    logic            part_en;
    logic [WM_W-1:0] wm_eff;

    assign rd_eop = pop_eop;

    pb_wm_resolve #(.WM_W(WM_W), .TX_MIN(TX_MIN)) u_cfg (
        .cfg_word (cfg_word),
        .cfg_tx   (cfg_tx),
        .multi    (wr_multi),
        .part_en  (part_en),
        .wm_eff   (wm_eff)
    );

    pb_fwd_ctrl #(.WM_W(WM_W), .TX_MIN(TX_MIN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_sop     (wr_sop),
        .wr_eop     (wr_eop),
        .rd_ready   (rd_ready),
        .full       (full),
        .empty      (empty),
        .pop_eop    (pop_eop),
        .part_en_in (part_en),
        .wm_in      (wm_eff),
        .tx_in      (cfg_tx),
        .wr_ready   (wr_ready),
        .push       (push),
        .rd_valid   (rd_valid),
        .pop        (pop)
    );

    pb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (wr_data),
        .push_eop  (wr_eop),
        .pop       (pop),
        .pop_data  (rd_data),
        .pop_eop   (pop_eop),
        .full      (full),
        .empty     (empty)
    );
endmodule

// File: tb/sim_cutthru_pktbuf.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_cutthru_pktbuf;
    localparam int CLK_P = 10;
    localparam int DW    = 8;
    localparam int DEP   = 32;
    localparam int WMW   = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [WMW:0]   cfg_word = '0;
    logic           cfg_tx = 1'b0;
    logic           wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0, wr_multi = 1'b0;
    logic [DW-1:0]  wr_data = '0;
    logic           wr_ready, rd_valid, rd_eop;
    logic           rd_ready = 1'b0;
    logic [DW-1:0]  rd_data;

    int n_chk = 0, n_bad = 0;
    int wr_n, rd_n;

    always #(CLK_P/2) clk = ~clk;

    cutthru_pktbuf #(.DATA_W(DW), .DEPTH(DEP), .WM_W(WMW), .TX_MIN(20)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_tx(cfg_tx),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_multi(wr_multi),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_eop(rd_eop)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic set_cfg(input bit tx, input bit en, input int wm);
        cfg_tx   = tx;
        cfg_word = {en, WMW'(wm)};
    endtask

    // Read out len bytes of a packet, checking order and end marker (R9), then R11.
    task automatic drain(input int len, input int seed, input string rq);
        rd_ready = 1'b1;
        for (int k = 0; k < len; k++) begin
            int w = 0;
            while (!rd_valid && w < 100) begin
                @(posedge clk); @(negedge clk); w++;
            end
            check(rd_valid && rd_data == DW'(seed + k), {rq, " R9 data"}, int'(rd_data), (seed + k) & 8'hFF);
            check(rd_eop == (k == len - 1), {rq, " R9 eop"}, int'(rd_eop), int'(k == len - 1));
            @(posedge clk); @(negedge clk);
        end
        rd_ready = 1'b0;
        check(wr_ready == 1'b1, "R11 reopen", int'(wr_ready), 1);
        check(rd_valid == 1'b0, "R11 idle", int'(rd_valid), 0);
    endtask

    // Write a packet with the reader held off; rd_valid must rise right after byte exp_start.
    task automatic write_pkt(input int len, input int seed, input bit multi, input int exp_start,
                             input bit chg, input string rq);
        rd_ready = 1'b0;
        for (int i = 1; i <= len; i++) begin
            wr_valid = 1'b1; wr_data = DW'(seed + i - 1);
            wr_sop = (i == 1); wr_eop = (i == len); wr_multi = multi;
            check(wr_ready == 1'b1, {rq, " wr_ready"}, int'(wr_ready), 1);
            @(posedge clk); @(negedge clk);
            if (chg && i == 1) set_cfg(~cfg_tx, ~cfg_word[WMW], 1);   // R8 stimulus
            check(rd_valid == (i >= exp_start), {rq, " start"}, int'(rd_valid), int'(i >= exp_start));
        end
        wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0; wr_multi = 1'b0;
        repeat (2) begin
            @(posedge clk); @(negedge clk);
            check(wr_ready == 1'b0, "R11 held", int'(wr_ready), 0);
        end
        drain(len, seed, rq);
    endtask

    // Concurrent write (one byte every gap+1 cycles) and read, continuing from wr_n/rd_n.
    task automatic stream(input int len, input int seed, input int gap, input string rq);
        int g = 0, stalls = 0;
        bit done = 1'b0;
        rd_ready = 1'b1;
        for (int c = 0; c < 2000 && !done; c++) begin
            bit wf, rf;
            wr_valid = (wr_n < len) && (g == 0);
            wr_data = DW'(seed + wr_n); wr_sop = (wr_n == 0); wr_eop = (wr_n == len - 1);
            #1;
            if (rd_valid) begin
                check(wr_n - rd_n > 0, "R10 valid when empty", wr_n - rd_n, 1);
                check(rd_data == DW'(seed + rd_n), {rq, " R9 order"}, int'(rd_data), (seed + rd_n) & 8'hFF);
                check(rd_eop == (rd_n == len - 1), {rq, " R9 eop"}, int'(rd_eop), int'(rd_n == len - 1));
            end else if (rd_n > 0 && wr_n == rd_n) stalls++;
            wf = wr_valid && wr_ready;
            rf = rd_valid;
            @(posedge clk);
            if (wf) wr_n++;
            if (rf) begin
                if (rd_n == len - 1) done = 1'b1;
                rd_n++;
            end
            g = (g >= gap) ? 0 : g + 1;
            @(negedge clk);
        end
        wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0; rd_ready = 1'b0;
        check(rd_n == len, {rq, " R9 count"}, rd_n, len);
        if (gap > 0) check(stalls > 0, "R10 stall seen", stalls, 1);
        check(wr_ready == 1'b1, "R11 reopen", int'(wr_ready), 1);
    endtask

    task automatic t_reset;
        check(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
        check(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
    endtask

    task automatic t_store_fwd;     // R2
        set_cfg(0, 0, 3);
        write_pkt(10, 8'h10, 0, 10, 0, "R2");
    endtask

    task automatic t_rx_wm;         // R3, R5
        set_cfg(0, 1, 3);
        write_pkt(10, 8'h20, 0, 3, 0, "R3");
        set_cfg(0, 1, 1);
        write_pkt(5, 8'h30, 0, 1, 0, "R5 wm1");
        set_cfg(0, 1, 0);
        write_pkt(5, 8'h38, 0, 1, 0, "R5 wm0");
    endtask

    task automatic t_tx_floor;      // R4
        set_cfg(1, 1, 5);
        write_pkt(24, 8'h40, 0, 20, 0, "R4 clamp");
        set_cfg(1, 1, 22);
        write_pkt(26, 8'h60, 0, 22, 0, "R4 above");
    endtask

    task automatic t_multi;         // R6
        set_cfg(1, 1, 22);
        write_pkt(28, 8'h80, 1, 28, 0, "R6");
    endtask

    task automatic t_early_eop;     // R7
        set_cfg(0, 1, 12);
        write_pkt(6, 8'hA0, 0, 6, 0, "R7");
    endtask

    task automatic t_cfg_midpkt;    // R8: start point follows the settings seen with the opening byte
        set_cfg(0, 1, 4);
        write_pkt(9, 8'hB0, 0, 4, 1, "R8 en");
        set_cfg(0, 0, 2);
        write_pkt(7, 8'hC0, 0, 7, 1, "R8 dis");
    endtask

    task automatic t_stray;         // R12
        set_cfg(0, 1, 1);
        wr_valid = 1'b1; wr_sop = 1'b0; wr_eop = 1'b1; wr_data = 8'hEE;
        check(wr_ready == 1'b1, "R12 taken", int'(wr_ready), 1);
        @(posedge clk); @(negedge clk);
        wr_valid = 1'b0; wr_eop = 1'b0;
        repeat (3) begin
            @(posedge clk); @(negedge clk);
            check(rd_valid == 1'b0, "R12 not stored", int'(rd_valid), 0);
        end
        write_pkt(3, 8'hD0, 0, 1, 0, "R12 next");
    endtask

    task automatic t_full;          // R9
        set_cfg(0, 1, 2);
        rd_ready = 1'b0;
        wr_n = 0; rd_n = 0;
        for (int i = 0; i < 40 && wr_ready; i++) begin
            wr_valid = 1'b1; wr_data = DW'(8'h05 + wr_n); wr_sop = (wr_n == 0); wr_eop = 1'b0;
            @(posedge clk); @(negedge clk);
            wr_n++;
        end
        wr_valid = 1'b0; wr_sop = 1'b0;
        check(wr_n == DEP, "R9 accepted until full", wr_n, DEP);
        check(wr_ready == 1'b0, "R9 ready low when full", int'(wr_ready), 0);
        stream(40, 8'h05, 0, "R9 full");
    endtask

    task automatic t_slow_writer;   // R10
        set_cfg(0, 1, 1);
        wr_n = 0; rd_n = 0;
        stream(12, 8'h70, 2, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_store_fwd();
        t_rx_wm();
        t_tx_floor();
        t_multi();
        t_early_eop();
        t_cfg_midpkt();
        t_stray();
        t_full();
        t_slow_writer();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule